// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Priority Arbiter

This block merges sixteen interrupt request lines into one interrupt signal toward a processor. The lines are split across two identical eight-input arbitration slices: a primary slice owning levels 0 to 7 and a secondary slice owning levels 8 to 15. Each slice has its own 8-bit block register, its own fixed-priority resolver and its own vector base. The secondary slice's combined request is fed into one input of the primary slice, so the processor sees a single sixteen-level source.

Software reaches the two block registers through a small register port with an 8-bit address. A global enable flag, set and cleared by two dedicated pulse inputs, gates every maskable request to the processor. When the processor acknowledges, the block registers the vector of the most urgent unblocked request present in that cycle and keeps it on its vector output until the next acknowledge.

Top module: `prio_irq_cascade`

## Requirements
- R1: After reset both block registers read FFh, the enable flag is clear, `int_out` is 0 and `vec_out` is 00h.
- R2: A write with `reg_wr` high stores `reg_wdata` in the primary block register at address 21h or the secondary one at address A1h, visible on `reg_rdata` from the next cycle; `reg_rdata` shows the addressed register combinationally and 00h for any other address, and writes to other addresses change neither register.
- R3: Bit n of the primary register governs level n and bit n of the secondary register governs level 8+n; a 1 blocks that request and a 0 lets it through.
- R4: `int_out` is high in the same cycle exactly when the enable flag is set and at least one unblocked request reaches the primary resolver.
- R5: `ien_set` sets the enable flag and `ien_clr` clears it, both taking effect on the next clock edge; when both are high, clearing wins.
- R6: Within each slice a lower level number always beats a higher one.
- R7: The secondary slice's combined unblocked request takes primary input 2, so its levels rank below levels 0 and 1 and above levels 3 to 7, and primary register bit 2 blocks all of them; `irq_req[2]` itself has no effect.
- R8: The vector for primary level n is 08h+n and for level 8+n it is 70h+n.
- R9: On a cycle with `int_ack` high and a pending unblocked request, the vector of the most urgent request of that cycle appears on `vec_out` after the edge and holds until the next such acknowledge; an acknowledge with nothing pending leaves `vec_out` unchanged.
- R10: A request that drops before the acknowledge cycle is not reported; one of higher priority that rises before it is reported instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 16 | Level-sensitive request lines, bit i is level i |
| reg_addr | input | 8 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ien_set | input | 1 | Pulse that sets the global enable |
| ien_clr | input | 1 | Pulse that clears the global enable |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Single-cycle acknowledge from the processor |
| vec_out | output | 8 | Registered vector of the last acknowledged request |

## Verification
The assertions take for granted that `int_ack` is a single-cycle pulse, that request lines stay high until acknowledged, and that every input changes away from the rising clock edge. The bench drives all inputs just after the falling edge, raises `int_ack` for exactly one cycle, and clears the request lines only after the acknowledge edge has passed. Sweeps cover every single level, every ordered pair of levels and a long run of pseudo-random request and block-register patterns, with the expected vector worked out arithmetically from the level ranking.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int VEC_W  = 8;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;
   typedef logic [VEC_W-1:0]  vec_t;
   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
   parameter int N_IN = 8,
   localparam int LW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic [N_IN-1:0] req,
   output logic            any,
   output logic [LW-1:0]   lvl
);
   // lowest set index wins: scan from the top so the last hit is the lowest
   always_comb begin
      any = 1'b0;
      lvl = '0;
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            lvl = i[LW-1:0];
         end
      end
   end
endmodule

// File: rtl/pic_slice.sv
module pic_slice
   import pic_pkg::*;
#(
   parameter int   N_IN  = 8,
   parameter vec_t VBASE = 8'h08,
   localparam int  LW    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] req,
   input  logic            wr_en,
   input  logic [N_IN-1:0] wdata,
   output logic [N_IN-1:0] mask_q,
   output logic            any,
   output logic [LW-1:0]   lvl,
   output vec_t            vec
);
   if (N_IN < 2 || N_IN > DATA_W) begin : g_bad_width
      $error("pic_slice: N_IN must lie between 2 and the register data width");
   end
   if (LW >= VEC_W) begin : g_bad_lw
      $error("pic_slice: level field does not fit the vector");
   end

   logic [N_IN-1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '1;
      else if (wr_en) mask_q <= wdata;
   end

   assign live = req & ~mask_q;

   pic_prio_enc #(.N_IN(N_IN)) u_enc (
      .req (live),
      .any (any),
      .lvl (lvl)
   );

   assign vec = VBASE + {{(VEC_W-LW){1'b0}}, lvl};

   assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mask_q == $past(wdata));

   assert_winner_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (req[lvl] && !mask_q[lvl]));

   assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((req & ~mask_q & ((N_IN'(1) << lvl) - N_IN'(1))) == '0));

   assert_idle_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !any |-> ((req & ~mask_q) == '0));
endmodule

// File: rtl/prio_irq_cascade.sv
module prio_irq_cascade
   import pic_pkg::*;
#(
   parameter int    SLICE_W   = 8,
   parameter int    CASC_IN   = 2,
   parameter addr_t PRI_ADDR  = 8'h21,
   parameter addr_t SEC_ADDR  = 8'hA1,
   parameter vec_t  PRI_VBASE = 8'h08,
   parameter vec_t  SEC_VBASE = 8'h70,
   localparam int   N_REQ     = 2 * SLICE_W,
   localparam int   LW        = $clog2(SLICE_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] irq_req,
   input  logic [7:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             ien_set,
   input  logic             ien_clr,
   output logic             int_out,
   input  logic             int_ack,
   output logic [7:0]       vec_out
);
   if (CASC_IN < 0 || CASC_IN >= SLICE_W) begin : g_bad_casc
      $error("prio_irq_cascade: cascade input outside the primary slice");
   end
   if (PRI_ADDR == SEC_ADDR) begin : g_bad_addr
      $error("prio_irq_cascade: register addresses collide");
   end

   localparam logic [SLICE_W-1:0] SLOT = SLICE_W'(1) << CASC_IN;

   logic [SLICE_W-1:0] sec_mask, pri_mask, pri_req;
   logic               sec_any, pri_any;
   logic [LW-1:0]      sec_lvl, pri_lvl;
   vec_t               sec_vec, pri_vec;
   logic               pri_wr, sec_wr;
   logic               ien_q;
   vec_t               vec_q;

   assign pri_wr = reg_wr && (reg_addr == PRI_ADDR);
   assign sec_wr = reg_wr && (reg_addr == SEC_ADDR);

   pic_slice #(.N_IN(SLICE_W), .VBASE(SEC_VBASE)) u_sec (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (irq_req[N_REQ-1:SLICE_W]),
      .wr_en  (sec_wr),
      .wdata  (reg_wdata[SLICE_W-1:0]),
      .mask_q (sec_mask),
      .any    (sec_any),
      .lvl    (sec_lvl),
      .vec    (sec_vec)
   );

   // the cascade slot carries the secondary slice, its own line is dropped
   assign pri_req = (irq_req[SLICE_W-1:0] & ~SLOT) | (sec_any ? SLOT : '0);

   pic_slice #(.N_IN(SLICE_W), .VBASE(PRI_VBASE)) u_pri (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (pri_req),
      .wr_en  (pri_wr),
      .wdata  (reg_wdata[SLICE_W-1:0]),
      .mask_q (pri_mask),
      .any    (pri_any),
      .lvl    (pri_lvl),
      .vec    (pri_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ien_q <= 1'b0;
      else if (ien_clr) ien_q <= 1'b0;
      else if (ien_set) ien_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vec_q <= '0;
      else if (int_ack && pri_any)
         vec_q <= (pri_lvl == LW'(CASC_IN)) ? sec_vec : pri_vec;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == PRI_ADDR)      reg_rdata = 8'(pri_mask);
      else if (reg_addr == SEC_ADDR) reg_rdata = 8'(sec_mask);
   end

   assign int_out = ien_q & pri_any;
   assign vec_out = vec_q;

   assert_int_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (irq_req != '0));

   assert_clr_drops_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr |=> !int_out);

   assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !int_ack |=> $stable(vec_out));

   assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && pri_any) |=>
         ((vec_out >= PRI_VBASE && vec_out < PRI_VBASE + 8'(SLICE_W)) ||
          (vec_out >= SEC_VBASE && vec_out < SEC_VBASE + 8'(SLICE_W))));

   assert_slot_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_mask[CASC_IN] && (irq_req[SLICE_W-1:0] & ~pri_mask & ~SLOT) == '0) |-> !pri_any);
endmodule

// File: tb/prio_irq_cascade_tb.sv
module prio_irq_cascade_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_req = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        ien_set = 1'b0;
   logic        ien_clr = 1'b0;
   logic        int_out;
   logic        int_ack = 1'b0;
   logic [7:0]  vec_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   prio_irq_cascade u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ien_set(ien_set), .ien_clr(ien_clr), .int_out(int_out),
      .int_ack(int_ack), .vec_out(vec_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic pulse_ack();
      int_ack = 1'b1;
      step();
      int_ack = 1'b0;
   endtask

   // ranking from the requirements: 0,1, then 8..15, then 3..7
   function automatic void model(input logic [15:0] rq, input logic [7:0] pm,
                                 input logic [7:0] sm, output bit hit, output logic [7:0] v);
      hit = 1'b0; v = '0;
      for (int k = 0; k < 2; k++)
         if (!hit && rq[k] && !pm[k]) begin hit = 1'b1; v = 8'h08 + 8'(k); end
      if (!pm[2])
         for (int k = 0; k < 8; k++)
            if (!hit && rq[8+k] && !sm[k]) begin hit = 1'b1; v = 8'h70 + 8'(k); end
      for (int k = 3; k < 8; k++)
         if (!hit && rq[k] && !pm[k]) begin hit = 1'b1; v = 8'h08 + 8'(k); end
   endfunction

   // drive a pattern, check int_out, acknowledge, check the vector
   task automatic run_case(input string tag, input logic [15:0] rq,
                           input logic [7:0] pm, input logic [7:0] sm);
      bit hit; logic [7:0] ev; logic [7:0] prev;
      model(rq, pm, sm, hit, ev);
      prev = vec_out;
      irq_req = rq;
      #1;
      chk({tag, " int_out R4"}, int_out, hit);
      pulse_ack();
      irq_req = '0;
      #1;
      chk({tag, " vector R8 R9"}, vec_out, hit ? ev : prev);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      reg_addr = 8'h21; #1; chk("R1 primary reg", reg_rdata, 8'hFF);
      reg_addr = 8'hA1; #1; chk("R1 secondary reg", reg_rdata, 8'hFF);
      chk("R1 vec_out", vec_out, 8'h00);
      irq_req = 16'hFFFF; #1;
      chk("R1 int_out", int_out, 1'b0);
      irq_req = '0;

      // R2 register port
      wr_reg(8'h21, 8'h5A);
      wr_reg(8'hA1, 8'hC3);
      reg_addr = 8'h21; #1; chk("R2 primary readback", reg_rdata, 8'h5A);
      reg_addr = 8'hA1; #1; chk("R2 secondary readback", reg_rdata, 8'hC3);
      wr_reg(8'h20, 8'h00);
      wr_reg(8'hA0, 8'h00);
      reg_addr = 8'h20; #1; chk("R2 other address reads zero", reg_rdata, 8'h00);
      reg_addr = 8'h21; #1; chk("R2 stray write primary", reg_rdata, 8'h5A);
      reg_addr = 8'hA1; #1; chk("R2 stray write secondary", reg_rdata, 8'hC3);

      // R5 enable flag with one unblocked request pending
      wr_reg(8'h21, 8'h00);
      wr_reg(8'hA1, 8'h00);
      irq_req = 16'h0010; #1;
      chk("R5 disabled", int_out, 1'b0);
      ien_set = 1'b1; step(); ien_set = 1'b0; #1;
      chk("R5 set", int_out, 1'b1);
      ien_clr = 1'b1; step(); ien_clr = 1'b0; #1;
      chk("R5 clear", int_out, 1'b0);
      ien_set = 1'b1; step(); #1;
      chk("R5 set again", int_out, 1'b1);
      ien_clr = 1'b1; step(); ien_set = 1'b0; ien_clr = 1'b0; #1;
      chk("R5 clear wins", int_out, 1'b0);
      ien_set = 1'b1; step(); ien_set = 1'b0;
      irq_req = '0;

      // R9 acknowledge with nothing pending keeps the vector
      run_case("R9 empty ack", 16'h0000, 8'h00, 8'h00);

      // R8 every single level, R7 line 2 ignored
      for (int i = 0; i < 16; i++)
         run_case($sformatf("R8 single %0d", i), 16'(1) << i, 8'h00, 8'h00);

      // R6 R7 every pair of levels
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            run_case($sformatf("R6 R7 pair %0d %0d", i, j),
                     (16'(1) << i) | (16'(1) << j), 8'h00, 8'h00);

      // R3 R7 pseudo-random requests and block registers
      lf = 16'hACE1;
      for (int n = 0; n < 300; n++) begin
         logic [7:0] pm, sm;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         pm = lf[7:0] ^ 8'(n);
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         sm = lf[15:8];
         wr_reg(8'h21, pm);
         wr_reg(8'hA1, sm);
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         run_case($sformatf("R3 mask case %0d", n), lf, pm, sm);
      end

      // R7 cascade slot blocked hides all secondary levels
      wr_reg(8'h21, 8'h04);
      wr_reg(8'hA1, 8'h00);
      run_case("R7 slot blocked", 16'hFF00, 8'h04, 8'h00);
      run_case("R7 slot blocked with level 6", 16'hFF40, 8'h04, 8'h00);

      // R10 dropped request and later higher-priority arrival
      wr_reg(8'h21, 8'h00);
      irq_req = 16'h0020; step();
      irq_req = 16'h0200; #1;
      chk("R10 still pending", int_out, 1'b1);
      pulse_ack(); irq_req = '0; #1;
      chk("R10 dropped not reported", vec_out, 8'h71);
      irq_req = 16'h0040; step();
      irq_req = 16'h0041; step();
      pulse_ack(); irq_req = '0; #1;
      chk("R10 higher arrival wins", vec_out, 8'h08);
      step(); step(); #1;
      chk("R9 vector held", vec_out, 8'h08);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule